// File: doc/BRIEF.md
# Segmented Address Relocation Unit

This block turns a 16-bit offset into a 20-bit physical memory address. It keeps four 16-bit segment registers (code, stack, data, extra). Each request carries a reference kind, an offset and an optional segment override. The block picks the segment from fixed per-kind rules and adds the selected register, shifted left by four, to the offset. The result, the segment that was used and a valid flag all come out of one register stage.

Some reference kinds are pinned to a single segment. An override request on one of these kinds is refused: the pinned segment is used anyway, and an error flag pulses together with the result. Software-visible segment values are loaded through a simple select/write-enable port. A load is seen by requests from the following cycle onward.

Top module: `seg_reloc_unit`

## Requirements
- R1: After reset `phys_valid` and `ovr_err` are 0 and all four segment registers hold 0, so a request then yields an address equal to its offset.
- R2: `phys_addr` equals (segment value × 16 + offset) modulo 2^20. The low four address bits always equal the low four offset bits.
- R3: Kinds fetch (code 0), stack (1) and string destination (4) use the code (segment 0), stack (1) and extra (3) segments respectively, whatever override is requested.
- R4: Kinds variable (2) and string source (3) default to the data segment (2). With `req_ovr_en` set, they use the segment given by `req_ovr_seg`, and no error is raised.
- R5: Kind BP-based (5) defaults to the stack segment (1). With `req_ovr_en` set, it uses `req_ovr_seg`, and no error is raised.
- R6: An override on kind 0, 1, 4, 6 or 7 is ignored, and `ovr_err` is 1 in the single cycle where that result is presented. In every other cycle it is 0.
- R7: `phys_valid` is 1 exactly one cycle after a cycle with `req_valid` high. Without a request, `phys_valid` is 0 and `phys_addr`/`phys_seg` keep their last values.
- R8: A write with `seg_wr_en` high loads `seg_wr_data` into segment `seg_wr_sel`. A request in the same cycle still sees the old value, and a request in the next cycle sees the new value.
- R9: `phys_seg` reports the segment number (0 code, 1 stack, 2 data, 3 extra) that formed `phys_addr`.
- R10: Reserved kinds 6 and 7 use the data segment (2) and cannot be overridden.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seg_wr_en | input | 1 | Segment register write enable |
| seg_wr_sel | input | 2 | Segment register to write |
| seg_wr_data | input | 16 | Value written to the segment register |
| req_valid | input | 1 | Translation request present |
| req_kind | input | 3 | Reference kind code |
| req_off | input | 16 | Offset within the segment |
| req_ovr_en | input | 1 | Override requested |
| req_ovr_seg | input | 2 | Segment named by the override |
| phys_valid | output | 1 | Result valid, one cycle after request |
| phys_addr | output | 20 | Physical address |
| phys_seg | output | 2 | Segment used for the address |
| ovr_err | output | 1 | Refused override, pulsed with the result |

## Verification
Every reference kind is applied both with and without an override. For the overridable kinds, each target segment is tried. The four segment registers are loaded with distinct values, so choosing the wrong register shows up in the address as well as in `phys_seg`.

One offset pushes the sum past the top of memory and checks the wrap. Another request follows reset with cleared segments, which isolates the offset path. A write issued in the same cycle as a request separates old-value from new-value reads. Idle cycles after a refused override show whether the error flag lasts one cycle and whether the outputs hold.

// File: rtl/sru_pkg.sv
package sru_pkg;
   localparam int NUM_SEGS = 4;
   localparam int SEG_SEL_W = $clog2(NUM_SEGS);

   typedef enum logic [SEG_SEL_W-1:0] {
      SEG_CODE  = 2'd0,
      SEG_STACK = 2'd1,
      SEG_DATA  = 2'd2,
      SEG_EXTRA = 2'd3
   } seg_id_e;

   typedef enum logic [2:0] {
      REF_FETCH   = 3'd0,
      REF_STACK   = 3'd1,
      REF_VAR     = 3'd2,
      REF_STR_SRC = 3'd3,
      REF_STR_DST = 3'd4,
      REF_BP_BASE = 3'd5,
      REF_RSV6    = 3'd6,
      REF_RSV7    = 3'd7
   } ref_kind_e;
endpackage

// File: rtl/sru_segfile.sv
module sru_segfile
   import sru_pkg::*;
#(
   parameter int SEG_W = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [SEG_SEL_W-1:0] wr_sel,
   input  logic [SEG_W-1:0]     wr_data,
   input  logic [SEG_SEL_W-1:0] rd_sel,
   output logic [SEG_W-1:0]     rd_data
);
   logic [SEG_W-1:0] seg_q [NUM_SEGS];

   generate
      if (SEG_W < 1) begin : g_bad_width
         $error("sru_segfile: SEG_W must be positive");
      end
      for (genvar i = 0; i < NUM_SEGS; i++) begin : g_seg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               seg_q[i] <= '0;
            end else if (wr_en && (wr_sel == SEG_SEL_W'(i))) begin
               seg_q[i] <= wr_data;
            end
         end

         assert_seg_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_sel == SEG_SEL_W'(i)) |=> (seg_q[i] == $past(wr_data)))
            else $error("segment %0d did not take written value", i);

         assert_seg_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && wr_sel == SEG_SEL_W'(i)) |=> $stable(seg_q[i]))
            else $error("segment %0d changed without a write", i);
      end
   endgenerate

   assign rd_data = seg_q[rd_sel];
endmodule

// File: rtl/sru_seg_select.sv
module sru_seg_select
   import sru_pkg::*;
(
   input  logic [2:0]           kind,
   input  logic                 ovr_en,
   input  logic [SEG_SEL_W-1:0] ovr_seg,
   output logic [SEG_SEL_W-1:0] seg,
   output logic                 refused
);
   seg_id_e dflt;
   logic    can_ovr;

   always_comb begin
      unique case (ref_kind_e'(kind))
         REF_FETCH:   begin dflt = SEG_CODE;  can_ovr = 1'b0; end
         REF_STACK:   begin dflt = SEG_STACK; can_ovr = 1'b0; end
         REF_VAR:     begin dflt = SEG_DATA;  can_ovr = 1'b1; end
         REF_STR_SRC: begin dflt = SEG_DATA;  can_ovr = 1'b1; end
         REF_STR_DST: begin dflt = SEG_EXTRA; can_ovr = 1'b0; end
         REF_BP_BASE: begin dflt = SEG_STACK; can_ovr = 1'b1; end
         default:     begin dflt = SEG_DATA;  can_ovr = 1'b0; end
      endcase
   end

   always_comb begin
      seg     = (ovr_en && can_ovr) ? ovr_seg : dflt;
      refused = ovr_en && !can_ovr;
   end
endmodule

// File: rtl/sru_addr_gen.sv
module sru_addr_gen #(
   parameter int SEG_W     = 16,
   parameter int OFF_W     = 16,
   parameter int SHIFT     = 4,
   parameter bit SPLIT_ADD = 1'b1
) (
   input  logic [SEG_W-1:0]       base_seg,
   input  logic [OFF_W-1:0]       off,
   output logic [SEG_W+SHIFT-1:0] addr
);
   localparam int ADDR_W = SEG_W + SHIFT;
   localparam int OFF_HI = OFF_W - SHIFT;

   generate
      if (SHIFT < 1 || OFF_W <= SHIFT) begin : g_bad_shift
         $error("sru_addr_gen: need 0 < SHIFT < OFF_W");
      end
      if (OFF_HI > SEG_W) begin : g_bad_off
         $error("sru_addr_gen: offset upper part wider than segment");
      end

      if (SPLIT_ADD) begin : g_split
         logic [SEG_W-1:0] hi_sum;
         always_comb begin
            hi_sum = base_seg + SEG_W'(off[OFF_W-1:SHIFT]);
            addr   = {hi_sum, off[SHIFT-1:0]};
         end
      end else begin : g_full
         always_comb begin
            addr = {base_seg, {SHIFT{1'b0}}} + ADDR_W'(off);
         end
      end
   endgenerate
endmodule

// File: rtl/seg_reloc_unit.sv
module seg_reloc_unit
   import sru_pkg::*;
#(
   parameter int SEG_W     = 16,
   parameter int OFF_W     = 16,
   parameter int SHIFT     = 4,
   parameter bit SPLIT_ADD = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   seg_wr_en,
   input  logic [1:0]             seg_wr_sel,
   input  logic [SEG_W-1:0]       seg_wr_data,
   input  logic                   req_valid,
   input  logic [2:0]             req_kind,
   input  logic [OFF_W-1:0]       req_off,
   input  logic                   req_ovr_en,
   input  logic [1:0]             req_ovr_seg,
   output logic                   phys_valid,
   output logic [SEG_W+SHIFT-1:0] phys_addr,
   output logic [1:0]             phys_seg,
   output logic                   ovr_err
);
   localparam int ADDR_W = SEG_W + SHIFT;

   generate
      if (SEG_SEL_W != 2) begin : g_bad_sel
         $error("seg_reloc_unit: segment select must be two bits");
      end
   endgenerate

   logic [SEG_SEL_W-1:0] sel_seg;
   logic                 sel_refused;
   logic [SEG_W-1:0]     sel_base;
   logic [ADDR_W-1:0]    sum_addr;

   sru_seg_select u_sel (
      .kind    (req_kind),
      .ovr_en  (req_ovr_en),
      .ovr_seg (req_ovr_seg),
      .seg     (sel_seg),
      .refused (sel_refused)
   );

   sru_segfile #(.SEG_W(SEG_W)) u_segs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (seg_wr_en),
      .wr_sel  (seg_wr_sel),
      .wr_data (seg_wr_data),
      .rd_sel  (sel_seg),
      .rd_data (sel_base)
   );

   sru_addr_gen #(
      .SEG_W     (SEG_W),
      .OFF_W     (OFF_W),
      .SHIFT     (SHIFT),
      .SPLIT_ADD (SPLIT_ADD)
   ) u_add (
      .base_seg (sel_base),
      .off      (req_off),
      .addr     (sum_addr)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phys_valid <= 1'b0;
         ovr_err    <= 1'b0;
         phys_addr  <= '0;
         phys_seg   <= '0;
      end else begin
         phys_valid <= req_valid;
         ovr_err    <= req_valid && sel_refused;
         if (req_valid) begin
            phys_addr <= sum_addr;
            phys_seg  <= sel_seg;
         end
      end
   end

   assert_pinned_kind_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_kind == REF_FETCH) |=> (phys_seg == SEG_CODE))
      else $error("fetch did not use code segment");

   assert_str_dst_extra_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_kind == REF_STR_DST) |=> (phys_seg == SEG_EXTRA))
      else $error("string destination did not use extra segment");

   assert_override_taken_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ovr_en &&
       (req_kind == REF_VAR || req_kind == REF_STR_SRC || req_kind == REF_BP_BASE))
      |=> (phys_seg == $past(req_ovr_seg) && !ovr_err))
      else $error("legal override not honoured");

   assert_err_with_result_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_err |-> (phys_valid && $past(req_ovr_en)))
      else $error("override error without a refused request");

   assert_addr_low_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (phys_addr[SHIFT-1:0] == $past(req_off[SHIFT-1:0])))
      else $error("low address bits differ from offset");

   assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> ($stable(phys_addr) && $stable(phys_seg) && !phys_valid))
      else $error("outputs moved without a request");
endmodule

// File: tb/seg_reloc_unit_tb.sv
`timescale 1ns/1ps
module seg_reloc_unit_tb;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        seg_wr_en;
   logic [1:0]  seg_wr_sel;
   logic [15:0] seg_wr_data;
   logic        req_valid;
   logic [2:0]  req_kind;
   logic [15:0] req_off;
   logic        req_ovr_en;
   logic [1:0]  req_ovr_seg;
   logic        phys_valid;
   logic [19:0] phys_addr;
   logic [1:0]  phys_seg;
   logic        ovr_err;

   int n_checks = 0;
   int n_fail   = 0;
   logic [15:0] seg_model [4];

   always #2.5 clk = ~clk;

   seg_reloc_unit u_dut (
      .clk(clk), .rst_n(rst_n),
      .seg_wr_en(seg_wr_en), .seg_wr_sel(seg_wr_sel), .seg_wr_data(seg_wr_data),
      .req_valid(req_valid), .req_kind(req_kind), .req_off(req_off),
      .req_ovr_en(req_ovr_en), .req_ovr_seg(req_ovr_seg),
      .phys_valid(phys_valid), .phys_addr(phys_addr),
      .phys_seg(phys_seg), .ovr_err(ovr_err)
   );

   // {kind[3], ovr_en, ovr_seg[2], offset[16], expected seg[2], expected err}
   localparam int NVEC = 20;
   localparam logic [24:0] VEC [NVEC] = '{
      {3'd0, 1'b0, 2'd0, 16'h0100, 2'd0, 1'b0},  // R3 fetch
      {3'd0, 1'b1, 2'd2, 16'h0200, 2'd0, 1'b1},  // R6 fetch override refused
      {3'd1, 1'b0, 2'd0, 16'hFFFE, 2'd1, 1'b0},  // R3 stack
      {3'd1, 1'b1, 2'd3, 16'h0010, 2'd1, 1'b1},  // R6
      {3'd2, 1'b0, 2'd0, 16'h0020, 2'd2, 1'b0},  // R4 + R2 wrap
      {3'd2, 1'b1, 2'd0, 16'h1234, 2'd0, 1'b0},  // R4
      {3'd2, 1'b1, 2'd1, 16'h0001, 2'd1, 1'b0},  // R4
      {3'd2, 1'b1, 2'd3, 16'hFFFF, 2'd3, 1'b0},  // R4
      {3'd2, 1'b1, 2'd2, 16'h0005, 2'd2, 1'b0},  // R4
      {3'd3, 1'b0, 2'd0, 16'h0008, 2'd2, 1'b0},  // R4 string source
      {3'd3, 1'b1, 2'd3, 16'h0040, 2'd3, 1'b0},  // R4
      {3'd3, 1'b1, 2'd0, 16'h0002, 2'd0, 1'b0},  // R4
      {3'd4, 1'b0, 2'd0, 16'h0300, 2'd3, 1'b0},  // R3 string dest
      {3'd4, 1'b1, 2'd2, 16'h0300, 2'd3, 1'b1},  // R6
      {3'd5, 1'b0, 2'd0, 16'h7777, 2'd1, 1'b0},  // R5
      {3'd5, 1'b1, 2'd2, 16'h000F, 2'd2, 1'b0},  // R5
      {3'd5, 1'b1, 2'd3, 16'hABCD, 2'd3, 1'b0},  // R5
      {3'd5, 1'b1, 2'd0, 16'h8000, 2'd0, 1'b0},  // R5
      {3'd6, 1'b0, 2'd0, 16'h0010, 2'd2, 1'b0},  // R10
      {3'd7, 1'b1, 2'd0, 16'h0010, 2'd2, 1'b1}   // R10 + R6
   };

   function automatic logic [19:0] model_addr(input logic [1:0] s, input logic [15:0] off);
      logic [20:0] full;
      full = {1'b0, seg_model[s], 4'h0} + {5'h0, off};
      return full[19:0];
   endfunction

   task automatic check(input string req, input logic ok,
                        input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic write_seg(input logic [1:0] s, input logic [15:0] v);
      @(negedge clk);
      seg_wr_en = 1'b1; seg_wr_sel = s; seg_wr_data = v;
      @(negedge clk);
      seg_wr_en = 1'b0;
      seg_model[s] = v;
   endtask

   task automatic do_req(input logic [2:0] k, input logic oe,
                         input logic [1:0] os, input logic [15:0] off);
      @(negedge clk);
      req_valid = 1'b1; req_kind = k; req_ovr_en = oe; req_ovr_seg = os; req_off = off;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   initial begin
      #(200000 * 5);
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      logic [19:0] held;
      rst_n = 1'b0; seg_wr_en = 1'b0; seg_wr_sel = '0; seg_wr_data = '0;
      req_valid = 1'b0; req_kind = '0; req_off = '0; req_ovr_en = 1'b0; req_ovr_seg = '0;
      for (int i = 0; i < 4; i++) seg_model[i] = '0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      check("R1 reset flags", phys_valid == 1'b0 && ovr_err == 1'b0,
            {30'd0, phys_valid, ovr_err}, 32'd0);
      do_req(3'd2, 1'b0, 2'd0, 16'h1234);
      check("R1 cleared segments", phys_valid && phys_addr == 20'h01234,
            {12'd0, phys_addr}, 32'h01234);

      write_seg(2'd0, 16'h1000);
      write_seg(2'd1, 16'h2345);
      write_seg(2'd2, 16'hFFFF);
      write_seg(2'd3, 16'h0ABC);

      // R2 R3 R4 R5 R6 R9 R10: vector table
      for (int v = 0; v < NVEC; v++) begin
         logic [2:0]  k;
         logic        oe;
         logic [1:0]  os;
         logic [15:0] off;
         logic [1:0]  es;
         logic        ee;
         logic [19:0] ea;
         {k, oe, os, off, es, ee} = VEC[v];
         ea = model_addr(es, off);
         do_req(k, oe, os, off);
         check($sformatf("R2/R9 vector %0d", v),
               phys_valid && phys_addr == ea && phys_seg == es && ovr_err == ee,
               {8'd0, phys_valid, ovr_err, phys_seg, phys_addr},
               {8'd0, 1'b1, ee, es, ea});
      end

      // R7 and R6: idle after refused override
      do_req(3'd4, 1'b1, 2'd0, 16'h0055);
      held = phys_addr;
      check("R6 error pulse", ovr_err == 1'b1, {31'd0, ovr_err}, 32'd1);
      @(negedge clk);
      check("R6 error one cycle", ovr_err == 1'b0, {31'd0, ovr_err}, 32'd0);
      check("R7 idle valid low and hold", !phys_valid && phys_addr == held && phys_seg == 2'd3,
            {10'd0, phys_valid, phys_seg, phys_addr}, {10'd0, 1'b0, 2'd3, held});

      // R8: write and request in the same cycle, then next cycle
      @(negedge clk);
      seg_wr_en = 1'b1; seg_wr_sel = 2'd2; seg_wr_data = 16'h0100;
      req_valid = 1'b1; req_kind = 3'd2; req_ovr_en = 1'b0; req_off = 16'h0003;
      @(negedge clk);
      seg_wr_en = 1'b0;
      check("R8 same-cycle sees old", phys_addr == model_addr(2'd2, 16'h0003),
            {12'd0, phys_addr}, {12'd0, model_addr(2'd2, 16'h0003)});
      seg_model[2] = 16'h0100;
      @(negedge clk);
      req_valid = 1'b0;
      check("R8 next cycle sees new", phys_valid && phys_addr == 20'h01003,
            {12'd0, phys_addr}, 32'h01003);

      // R7: back-to-back requests both produce results
      @(negedge clk);
      req_valid = 1'b1; req_kind = 3'd0; req_ovr_en = 1'b0; req_off = 16'h0004;
      @(negedge clk);
      check("R7 first of pair", phys_valid && phys_addr == 20'h10004,
            {12'd0, phys_addr}, 32'h10004);
      req_kind = 3'd1; req_off = 16'h0006;
      @(negedge clk);
      req_valid = 1'b0;
      check("R7 second of pair", phys_valid && phys_addr == 20'h23456 && phys_seg == 2'd1,
            {12'd0, phys_addr}, 32'h23456);

      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end
endmodule